// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer

A 16-bit counter that advances once per enable tick and whose counting rule is picked by a 4-bit mode number. The mode decides the ceiling of the count. That ceiling can be one of four fixed values (0x00FF, 0x01FF, 0x03FF, 0xFFFF), the buffered value of compare channel A, or the capture value supplied by the host. The mode also decides whether the count wraps or runs up and down.

Each mode further sets when the two compare channels copy their host values into their active copies: every clock, at the ceiling, or at zero. It also sets where the overflow pulse is produced: at all-ones, at the ceiling, or at zero. Two pulse-width outputs follow the active compare values. A single-slope output goes high at zero and low on a match. A dual-slope output goes low on a match while rising and high on a match while falling. Prescaling and capture hardware live outside the block; the capture value simply arrives as an input.

Top module: `mm_wave_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the count, overflow pulse, both match pulses and both PWM outputs are 0, and the next count direction is up.
- R2: Mode 0 counts 0 to 0xFFFF and wraps to 0; the overflow pulse appears for the tick taken at 0xFFFF.
- R3: Mode 4 (ceiling = active compare A) and mode 12 (ceiling = capture input) count 0 to the ceiling and return to 0; overflow only at 0xFFFF.
- R4: Modes 5, 6 and 7 wrap at 0x00FF, 0x01FF and 0x03FF; overflow for the tick taken at the ceiling.
- R5: Mode 14 (ceiling = capture input) and mode 15 (ceiling = active compare A) behave as R4 with their own ceiling.
- R6: Modes 1, 2, 3 (ceilings 0x00FF, 0x01FF, 0x03FF), 10 (capture) and 11 (active compare A) count up to the ceiling, then down to 0, visiting each end once per period of 2×ceiling ticks; overflow for the tick taken at 0.
- R7: Modes 8 (capture) and 9 (active compare A) count as R6; overflow for the tick taken at 0.
- R8: Active compare values load from the host inputs on every clock in modes 0, 4, 12; on a tick taken at the ceiling in modes 1, 2, 3, 10, 11; on a tick taken at 0 in modes 5, 6, 7, 8, 9, 14, 15.
- R9: A match pulse for a channel is high for one clock after a tick taken while the count equals that channel's active compare value.
- R10: In modes 5, 6, 7, 14, 15 a PWM output goes high after a tick taken at 0 and low after a tick taken at a match; a match at 0 keeps it low.
- R11: In modes 1, 2, 3, 8, 9, 10, 11 a PWM output goes low after a match taken while counting up (including at the ceiling) and high after a match taken while counting down.
- R12: Mode 13 is reserved: ticks leave the count and PWM outputs unchanged and produce no overflow or match pulses.
- R13: With tick_i low the count does not change and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable, one step per high clock |
| mode_i | input | 4 | Waveform mode number 0..15 |
| cmp_a_i | input | 16 | Host value for compare channel A |
| cmp_b_i | input | 16 | Host value for compare channel B |
| cap_i | input | 16 | Capture value usable as ceiling |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Overflow pulse |
| match_a_o | output | 1 | Channel A match pulse |
| match_b_o | output | 1 | Channel B match pulse |
| pwm_a_o | output | 1 | Channel A waveform |
| pwm_b_o | output | 1 | Channel B waveform |

## Verification
Every result is registered on the clock edge that takes the tick, so the count, the overflow pulse, the match pulses and the PWM levels are due one clock after the tick is presented. The compare values seen at that edge are the active copies as they stood before it. The bench drives tick and host values on the falling edge, lets exactly one rising edge pass and samples on the next falling edge, so each check reads the state produced by one known tick. When a host value is written in the every-clock load modes, the bench inserts an idle clock before the next tick, because the new value becomes active only one edge after the write.

// File: rtl/mwt_pkg.sv
// Shared types for the multi-mode waveform timer.
// Assumes a 4-bit mode number; decode_mode maps it to a configuration record.
package mwt_pkg;

    typedef enum logic [2:0] {TS_FIX8, TS_FIX9, TS_FIX10, TS_FULL, TS_REG_A, TS_CAP} top_src_e;
    typedef enum logic [1:0] {LD_ALWAYS, LD_AT_TOP, LD_AT_BOT} load_pt_e;
    typedef enum logic [1:0] {OV_AT_MAX, OV_AT_TOP, OV_AT_BOT} ovf_pt_e;
    typedef enum logic [1:0] {WV_OFF, WV_SINGLE, WV_DUAL} wave_e;

    typedef struct packed {
        logic      valid;
        logic      dual;
        top_src_e  top_src;
        load_pt_e  load_pt;
        ovf_pt_e   ovf_pt;
        wave_e     wave;
    } mode_cfg_t;

    // Map a mode number to ceiling source, slope, load point, overflow point and waveform.
    function automatic mode_cfg_t decode_mode(input logic [3:0] m);
        mode_cfg_t c;
        c.valid   = 1'b1;
        c.dual    = 1'b0;
        c.top_src = TS_FULL;
        c.load_pt = LD_ALWAYS;
        c.ovf_pt  = OV_AT_MAX;
        c.wave    = WV_OFF;
        case (m)
            4'd1, 4'd2, 4'd3, 4'd10, 4'd11: begin
                c.dual    = 1'b1;
                c.load_pt = LD_AT_TOP;
                c.ovf_pt  = OV_AT_BOT;
                c.wave    = WV_DUAL;
            end
            4'd8, 4'd9: begin
                c.dual    = 1'b1;
                c.load_pt = LD_AT_BOT;
                c.ovf_pt  = OV_AT_BOT;
                c.wave    = WV_DUAL;
            end
            4'd5, 4'd6, 4'd7, 4'd14, 4'd15: begin
                c.load_pt = LD_AT_BOT;
                c.ovf_pt  = OV_AT_TOP;
                c.wave    = WV_SINGLE;
            end
            4'd13: begin
                c.valid   = 1'b0;
                c.load_pt = LD_AT_TOP;
            end
            default: ;
        endcase
        case (m)
            4'd1, 4'd5:                  c.top_src = TS_FIX8;
            4'd2, 4'd6:                  c.top_src = TS_FIX9;
            4'd3, 4'd7:                  c.top_src = TS_FIX10;
            4'd4, 4'd9, 4'd11, 4'd15:    c.top_src = TS_REG_A;
            4'd8, 4'd10, 4'd12, 4'd14:   c.top_src = TS_CAP;
            default:                     c.top_src = TS_FULL;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mwt_mode_dec.sv
// Mode decoder and ceiling selector.
// Assumes CNT_W >= 10 so that the fixed 8/9/10-bit ceilings fit.
module mwt_mode_dec
    import mwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       mode_i,
    input  logic [CNT_W-1:0] act_a_i,
    input  logic [CNT_W-1:0] cap_i,
    output logic             valid_o,
    output logic             dual_o,
    output load_pt_e         load_pt_o,
    output ovf_pt_e          ovf_pt_o,
    output wave_e            wave_o,
    output logic [CNT_W-1:0] top_o
);

    localparam logic [CNT_W-1:0] TOP_8    = CNT_W'(255);
    localparam logic [CNT_W-1:0] TOP_9    = CNT_W'(511);
    localparam logic [CNT_W-1:0] TOP_10   = CNT_W'(1023);
    localparam logic [CNT_W-1:0] TOP_FULL = '1;

    mode_cfg_t cfg;

    // Decode the mode number into its configuration record.
    always_comb cfg = decode_mode(mode_i);

    assign valid_o   = cfg.valid;
    assign dual_o    = cfg.dual;
    assign load_pt_o = cfg.load_pt;
    assign ovf_pt_o  = cfg.ovf_pt;
    assign wave_o    = cfg.wave;

    // Select the ceiling from its configured source.
    always_comb begin
        case (cfg.top_src)
            TS_FIX8:  top_o = TOP_8;
            TS_FIX9:  top_o = TOP_9;
            TS_FIX10: top_o = TOP_10;
            TS_REG_A: top_o = act_a_i;
            TS_CAP:   top_o = cap_i;
            default:  top_o = TOP_FULL;
        endcase
    end

endmodule

// File: rtl/mwt_counter.sv
// Up or up/down counter with overflow pulse.
// Assumes tick_i is a one-clock enable; a zero ceiling in dual-slope holds the count at 0.
module mwt_counter
    import mwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             valid_i,
    input  logic             dual_i,
    input  ovf_pt_e          ovf_pt_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic             at_top_o,
    output logic             at_bot_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic             ovf_q;
    logic             at_max;
    logic             ovf_hit;
    logic             step;

    assign at_top_o = (cnt_q == top_i);
    assign at_bot_o = (cnt_q == '0);
    assign at_max   = (cnt_q == CNT_MAX);
    assign step     = tick_i && valid_i;

    // Pick the end point at which this mode raises overflow.
    always_comb begin
        case (ovf_pt_i)
            OV_AT_TOP: ovf_hit = at_top_o;
            OV_AT_BOT: ovf_hit = at_bot_o;
            default:   ovf_hit = at_max;
        endcase
    end

    // Advance the count and direction on each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (step) begin
            if (!dual_i) begin
                up_q  <= 1'b1;
                cnt_q <= at_top_o ? '0 : cnt_q + ONE;
            end else if (top_i == '0) begin
                up_q  <= 1'b1;
                cnt_q <= '0;
            end else if (up_q) begin
                if (at_top_o) begin
                    up_q  <= 1'b0;
                    cnt_q <= cnt_q - ONE;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else begin
                if (at_bot_o) begin
                    up_q  <= 1'b1;
                    cnt_q <= ONE;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    // Register the one-clock overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= step && ovf_hit;
    end

    assign cnt_o = cnt_q;
    assign up_o  = up_q;
    assign ovf_o = ovf_q;

    // R4: a single-slope count leaves its ceiling for zero
    a_r4_single_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && valid_i && !dual_i && at_top_o |=> cnt_q == '0);

    // R6: a dual-slope count inside its range moves by exactly one
    a_r6_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && valid_i && dual_i && top_i != '0 && cnt_q <= top_i
        |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));

    // R12: reserved mode leaves the count alone and gives no overflow
    a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cnt_q) && !ovf_q);

    // R13: without a tick the count holds
    a_r13_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q) && !ovf_q);

endmodule

// File: rtl/mwt_chan.sv
// One compare channel: buffered compare value, match pulse and waveform output.
// Assumes count, direction and end-point flags come from mwt_counter in the same cycle.
module mwt_chan
    import mwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             valid_i,
    input  load_pt_e         load_pt_i,
    input  wave_e            wave_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             up_i,
    input  logic             at_top_i,
    input  logic             at_bot_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] act_o,
    output logic             match_o,
    output logic             pwm_o
);

    logic [CNT_W-1:0] act_q;
    logic             match_q;
    logic             pwm_q;
    logic             load;
    logic             hit;
    logic             step;

    assign hit  = (cnt_i == act_q);
    assign step = tick_i && valid_i;

    // Decide whether the active compare value takes the host value this clock.
    always_comb begin
        case (load_pt_i)
            LD_ALWAYS: load = valid_i;
            LD_AT_TOP: load = step && at_top_i;
            LD_AT_BOT: load = step && at_bot_i;
            default:   load = 1'b0;
        endcase
    end

    // Hold the active compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= cmp_i;
    end

    // Register the one-clock match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= step && hit;
    end

    // Drive the waveform level per slope type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (step) begin
            case (wave_i)
                WV_SINGLE: begin
                    if (hit)           pwm_q <= 1'b0;
                    else if (at_bot_i) pwm_q <= 1'b1;
                end
                WV_DUAL:   if (hit) pwm_q <= !up_i;
                default:   pwm_q <= 1'b0;
            endcase
        end
    end

    assign act_o   = act_q;
    assign match_o = match_q;
    assign pwm_o   = pwm_q;

    // R8: in every-clock load modes the active value follows the host one edge later
    a_r8_imm_follow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && load_pt_i == LD_ALWAYS |=> act_q == $past(cmp_i));

    // R9: a match pulse is always the result of a tick
    a_r9_match_tick: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> $past(tick_i) && $past(valid_i));

    // R10: a single-slope match drives the output low
    a_r10_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && valid_i && wave_i == WV_SINGLE && hit |=> !pwm_q);

    // R11: a dual-slope match while falling drives the output high
    a_r11_dual_set: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && valid_i && wave_i == WV_DUAL && hit && !up_i |=> pwm_q);

endmodule

// File: rtl/mm_wave_timer.sv
// Multi-mode waveform timer top: decoder, counter and a generated set of compare channels.
// Assumes channel 0 is compare A (usable as ceiling) and channel 1 is compare B.
module mm_wave_timer
    import mwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [3:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic [CNT_W-1:0] cap_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             match_a_o,
    output logic             match_b_o,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);

    localparam int NUM_CH = 2;

    logic             valid_w;
    logic             dual_w;
    load_pt_e         load_pt_w;
    ovf_pt_e          ovf_pt_w;
    wave_e            wave_w;
    logic [CNT_W-1:0] top_w;
    logic [CNT_W-1:0] cnt_w;
    logic             up_w;
    logic             at_top_w;
    logic             at_bot_w;

    logic [CNT_W-1:0] cmp_w   [NUM_CH];
    logic [CNT_W-1:0] act_w   [NUM_CH];
    logic             match_w [NUM_CH];
    logic             pwm_w   [NUM_CH];

    assign cmp_w[0] = cmp_a_i;
    assign cmp_w[1] = cmp_b_i;

    mwt_mode_dec #(.CNT_W(CNT_W)) u_dec (
        .mode_i    (mode_i),
        .act_a_i   (act_w[0]),
        .cap_i     (cap_i),
        .valid_o   (valid_w),
        .dual_o    (dual_w),
        .load_pt_o (load_pt_w),
        .ovf_pt_o  (ovf_pt_w),
        .wave_o    (wave_w),
        .top_o     (top_w)
    );

    mwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .valid_i  (valid_w),
        .dual_i   (dual_w),
        .ovf_pt_i (ovf_pt_w),
        .top_i    (top_w),
        .cnt_o    (cnt_w),
        .up_o     (up_w),
        .at_top_o (at_top_w),
        .at_bot_o (at_bot_w),
        .ovf_o    (ovf_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mwt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .valid_i   (valid_w),
            .load_pt_i (load_pt_w),
            .wave_i    (wave_w),
            .cnt_i     (cnt_w),
            .up_i      (up_w),
            .at_top_i  (at_top_w),
            .at_bot_i  (at_bot_w),
            .cmp_i     (cmp_w[g]),
            .act_o     (act_w[g]),
            .match_o   (match_w[g]),
            .pwm_o     (pwm_w[g])
        );
    end

    assign count_o   = cnt_w;
    assign match_a_o = match_w[0];
    assign match_b_o = match_w[1];
    assign pwm_a_o   = pwm_w[0];
    assign pwm_b_o   = pwm_w[1];

    // R8: a load-at-zero channel keeps its active value unless a tick is taken at zero
    a_r8_bot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_w && load_pt_w == LD_AT_BOT && !(tick_i && at_bot_w)
        |=> $stable(act_w[NUM_CH-1]));

    // R12: reserved mode gives no match pulses
    a_r12_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_w |=> !match_a_o && !match_b_o);

endmodule

// File: tb/mm_wave_timer_tb_top.sv
// Directed bench for mm_wave_timer; one task per scenario.
module mm_wave_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] cmp_a = '0, cmp_b = '0, cap = '0;
    logic [15:0] count;
    logic        ovf, match_a, match_b, pwm_a, pwm_b;

    int n_vec = 0;
    int n_bad = 0;
    int hits_a = 0, hits_b = 0, hits_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_wave_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
        .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cap_i(cap),
        .count_o(count), .ovf_o(ovf), .match_a_o(match_a), .match_b_o(match_b),
        .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] m);
        rst_n = 1'b0;
        tick  = 1'b0;
        mode  = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hits_a = 0; hits_b = 0; hits_ovf = 0;
    endtask

    task automatic step();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (match_a) hits_a++;
        if (match_b) hits_b++;
        if (ovf)     hits_ovf++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int wpos(input int p, input int top, input bit dual);
        if (dual && p > top) return 2*top - p;
        return p;
    endfunction

    // Walk n ticks from count 0 and check count and overflow against the mode's rule.
    task automatic chk_wave(input string req, input int top, input bit dual,
                            input int ovsel, input int n);
        int per = dual ? 2*top : top + 1;
        for (int p = 0; p < n; p++) begin
            int c = wpos(p % per, top, dual);
            int q = wpos((p + 1) % per, top, dual);
            int eo;
            eo = (ovsel == 0) ? (c == 65535) : (ovsel == 1) ? (c == top) : (c == 0);
            step();
            check(req, "count", int'(count), q);
            check(req, "ovf", int'(ovf), eo);
        end
    endtask

    task automatic t_reset();
        do_reset(4'd0);
        check("R1", "count", int'(count), 0);
        check("R1", "ovf", int'(ovf), 0);
        check("R1", "match", int'(match_a | match_b), 0);
        check("R1", "pwm", int'(pwm_a | pwm_b), 0);
    endtask

    task automatic t_no_tick();
        do_reset(4'd5);
        repeat (3) step();
        idle(6);
        check("R13", "count held", int'(count), 3);
        check("R13", "ovf quiet", int'(ovf), 0);
    endtask

    task automatic t_normal();
        do_reset(4'd0);
        cmp_b = 16'h1234;
        idle(1);
        chk_wave("R2", 65535, 1'b0, 0, 65536);
        check("R9", "match_b pulses in one wrap", hits_b, 1);
        cmp_b = '0;
    endtask

    task automatic t_ctc();
        do_reset(4'd4);
        cmp_a = 16'd9;
        idle(2);
        chk_wave("R3", 9, 1'b0, 0, 30);
        cmp_a = 16'd5;
        idle(2);
        chk_wave("R3", 5, 1'b0, 0, 12);
        check("R8", "immediate ceiling change", int'(count), 0);
        do_reset(4'd12);
        cap = 16'd4;
        chk_wave("R3", 4, 1'b0, 0, 15);
    endtask

    task automatic t_fast_fixed();
        do_reset(4'd5);  chk_wave("R4", 255, 1'b0, 1, 259);
        do_reset(4'd6);  chk_wave("R4", 511, 1'b0, 1, 515);
        do_reset(4'd7);  chk_wave("R4", 1023, 1'b0, 1, 1027);
    endtask

    task automatic t_fast_reg();
        do_reset(4'd4);
        cmp_a = 16'd7;
        idle(2);
        mode = 4'd15;
        chk_wave("R5", 7, 1'b0, 1, 20);
        do_reset(4'd14);
        cap = 16'd11;
        chk_wave("R5", 11, 1'b0, 1, 30);
    endtask

    task automatic t_dual();
        do_reset(4'd1);  chk_wave("R6", 255, 1'b1, 2, 513);
        do_reset(4'd2);  chk_wave("R6", 511, 1'b1, 2, 1025);
        do_reset(4'd3);  chk_wave("R6", 1023, 1'b1, 2, 2049);
        do_reset(4'd10); cap = 16'd6;
        chk_wave("R6", 6, 1'b1, 2, 30);
        do_reset(4'd4);  cmp_a = 16'd6; idle(2);
        mode = 4'd11;
        chk_wave("R6", 6, 1'b1, 2, 30);
    endtask

    task automatic t_pfc();
        do_reset(4'd8);  cap = 16'd20;
        chk_wave("R7", 20, 1'b1, 2, 45);
        do_reset(4'd4);  cmp_a = 16'd9; idle(2);
        mode = 4'd9;
        chk_wave("R7", 9, 1'b1, 2, 20);
    endtask

    // Single-slope waveform, with a compare write that must wait for zero.
    task automatic t_fast_pwm();
        do_reset(4'd5);
        cmp_a = 16'h10;
        cmp_b = 16'h0;
        repeat (256) step();
        hits_a = 0;
        for (int i = 0; i < 256; i++) begin
            if (i == 16'h40) cmp_a = 16'h20;
            step();
            check("R10", "pwm_a period 2", int'(pwm_a), (i < 16'h10) ? 1 : 0);
            check("R9", "match_a period 2", int'(match_a), (i == 16'h10) ? 1 : 0);
        end
        for (int i = 0; i < 256; i++) begin
            step();
            check("R8", "pwm_a after load at zero", int'(pwm_a), (i < 16'h20) ? 1 : 0);
        end
        check("R10", "pwm_b with compare 0 stays low", int'(pwm_b), 0);
        check("R9", "match_a pulses", hits_a, 2);
    endtask

    // Dual-slope waveform, with a compare write that must wait for the ceiling.
    task automatic t_pc_pwm();
        int kup, kdn, p_set;
        do_reset(4'd1);
        cmp_a = 16'h40;
        repeat (510) step();
        check("R11", "pwm_a high after falling match", int'(pwm_a), 1);
        for (int per = 0; per < 2; per++) begin
            kup = (per == 0) ? 16'h40 : 16'h80;
            kdn = 16'h80;
            p_set = 510 - kdn;
            for (int p = 0; p < 510; p++) begin
                if (per == 0 && p == 100) cmp_a = 16'h80;
                step();
                check("R11", "pwm_a level", int'(pwm_a), (p < kup || p >= p_set) ? 1 : 0);
                check("R8", "match_a at load-at-ceiling value", int'(match_a),
                      (p == kup || p == p_set) ? 1 : 0);
            end
        end
    endtask

    task automatic t_reserved();
        do_reset(4'd0);
        cmp_a = 16'd5;
        repeat (5) step();
        mode = 4'd13;
        hits_a = 0; hits_b = 0; hits_ovf = 0;
        repeat (8) step();
        check("R12", "count held", int'(count), 5);
        check("R12", "no match pulses", hits_a + hits_b, 0);
        check("R12", "no overflow", hits_ovf, 0);
        check("R12", "pwm unchanged", int'(pwm_a), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (R1..) actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_no_tick();
        t_normal();
        t_ctc();
        t_fast_fixed();
        t_fast_reg();
        t_dual();
        t_pfc();
        t_fast_pwm();
        t_pc_pwm();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule